// File: doc/BRIEF.md
# Adaptive Non-Overlap Half-Bridge Gate Sequencer

This block turns a three-level PWM command into the two gate enables of a synchronous half-bridge, one instance per phase. Ahead of the block, comparators have already reduced the PWM voltage to three digital flags: above the rising level, below the falling level, and inside the middle window. Three more comparator flags report that the lower gate, the switch node and the upper gate-to-switch voltage have each dropped below a fixed level. No dead time is counted. Each gate is released only after the flag shows that the opposite device has really turned off.

Every asynchronous input passes through a two-flop synchronizer. A gate output therefore responds three clock edges after its input changes. A programmable timeout bounds each wait for a feedback flag. If the flag never arrives, the channel shuts both gates and latches a fault, which clears only when the channel enable goes low. The top level holds two channels. They share one power-good input and each has its own enable.

Top module: `gate_seq_pair`

## Requirements
- R1: In no cycle are the upper and lower gate outputs of one channel high together.
- R2: While power-good is low, both gates of every channel are low from the third clock edge after it falls, whatever the other inputs are.
- R3: While a channel's enable is low, both of its gates and its fault flag are low. When enable rises, the channel passes through an initialization state with both gates low before it follows PWM, and the other channel is unaffected.
- R4: The PWM command is decoded as HIGH when only the high flag is set, as LOW when only the low flag is set, and as shutdown in every other case: the mid flag set, high and low both set, or no flag set (a floating input). Shutdown drives both gates low.
- R5: On a HIGH command, the lower gate drops first. The upper gate rises only after the synchronized lower-gate-below-level flag has been seen true, and it then stays high.
- R6: On a LOW command, the upper gate drops first. The lower gate rises only after the switch-node-below-level and upper-gate-below-level flags have both been seen true.
- R7: The bootstrap switch enable equals the lower gate output in every cycle.
- R8: If a wait for a feedback flag lasts more than the timeout limit plus one cycle, the channel turns both gates off and raises its fault flag. The fault stays set, with the gates held low, until the channel enable goes low.
- R9: If PWM reverses while a channel waits for a flag, the pending transition is dropped. The opposite sequence then starts with both gates still low, and the abandoned gate never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pgood_i | input | 1 | Shared power-good (asynchronous) |
| en_i | input | NCH | Per-channel enable (asynchronous) |
| pwm_hi_i | input | NCH | PWM above the rising level |
| pwm_lo_i | input | NCH | PWM below the falling level |
| pwm_mid_i | input | NCH | PWM inside the middle window |
| lg_low_i | input | NCH | Lower gate below the turn-off level |
| sw_low_i | input | NCH | Switch node below the turn-off level |
| ug_low_i | input | NCH | Upper gate-to-switch voltage below the turn-off level |
| tmo_lim_i | input | TW | Timeout limit for a wait, in cycles |
| ug_o | output | NCH | Upper gate command |
| lg_o | output | NCH | Lower gate command |
| boot_o | output | NCH | Bootstrap switch enable |
| fault_o | output | NCH | Feedback-timeout fault |

## Verification
The risky coincidence is a PWM reversal that lands in the same cycle as a feedback flag arrives, or as the timeout counter expires. This decides whether the abandoned gate rises, whether a fault latches, or whether the reversed sequence begins.

The bench models each feedback flag as its gate output delayed by a random number of cycles, and it flips commands at random moments against those delays. It also holds a flag low on purpose to make the wait run long, then reverses the command inside the timeout window. Every cycle it checks that the gates never overlap. On each gate rise it checks that the matching flag was present three cycles earlier, and it checks that a reversed wait never raised the abandoned gate.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_INIT    = 3'd1,
        ST_LOW_ON  = 3'd2,
        ST_WAIT_HI = 3'd3,
        ST_HIGH_ON = 3'd4,
        ST_WAIT_LO = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_SHUT = 2'd0,
        CMD_HIGH = 2'd1,
        CMD_LOW  = 2'd2
    } pwm_cmd_e;

    // Exactly one of high/low with no mid flag is a valid level; all else is shutdown
    function automatic pwm_cmd_e decode_pwm(input logic hi, input logic lo, input logic mid);
        pwm_cmd_e c;
        if (!mid && hi && !lo)      c = CMD_HIGH;
        else if (!mid && lo && !hi) c = CMD_LOW;
        else                        c = CMD_SHUT;
        return c;
    endfunction

endpackage

// File: rtl/gate_seq_sync.sv
module gate_seq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[0] <= '0;
                else        stg_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gate_seq_chan.sv
module gate_seq_chan
    import gate_seq_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pg_s,
    input  logic          en_s,
    input  logic          hi_s,
    input  logic          lo_s,
    input  logic          mid_s,
    input  logic          lgl_s,
    input  logic          swl_s,
    input  logic          ugl_s,
    input  logic [TW-1:0] tmo_lim,
    output logic          ug_o,
    output logic          lg_o,
    output logic          boot_o,
    output logic          fault_o
);
    typedef struct packed {
        seq_state_e    st;
        logic [TW-1:0] cnt;
        logic          fault;
    } chan_regs_t;

    chan_regs_t cur_q, nxt_d;
    pwm_cmd_e   cmd;

    always_comb begin
        nxt_d = cur_q;
        cmd   = decode_pwm(hi_s, lo_s, mid_s);
        if (!en_s) begin
            nxt_d.st    = ST_OFF;
            nxt_d.cnt   = '0;
            nxt_d.fault = 1'b0;
        end else if (!pg_s) begin
            nxt_d.st  = ST_OFF;
            nxt_d.cnt = '0;
        end else begin
            unique case (cur_q.st)
                ST_OFF: begin
                    if (!cur_q.fault) nxt_d.st = ST_INIT;
                end
                ST_INIT: begin
                    nxt_d.cnt = '0;
                    if (cmd == CMD_HIGH)     nxt_d.st = ST_WAIT_HI;
                    else if (cmd == CMD_LOW) nxt_d.st = ST_WAIT_LO;
                end
                ST_WAIT_HI: begin
                    if (cmd == CMD_SHUT) begin
                        nxt_d.st = ST_INIT;
                    end else if (cmd == CMD_LOW) begin
                        nxt_d.st  = ST_WAIT_LO;
                        nxt_d.cnt = '0;
                    end else if (lgl_s) begin
                        nxt_d.st = ST_HIGH_ON;
                    end else if (cur_q.cnt == tmo_lim) begin
                        nxt_d.st    = ST_OFF;
                        nxt_d.fault = 1'b1;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_HIGH_ON: begin
                    nxt_d.cnt = '0;
                    if (cmd == CMD_LOW)       nxt_d.st = ST_WAIT_LO;
                    else if (cmd == CMD_SHUT) nxt_d.st = ST_INIT;
                end
                ST_WAIT_LO: begin
                    if (cmd == CMD_SHUT) begin
                        nxt_d.st = ST_INIT;
                    end else if (cmd == CMD_HIGH) begin
                        nxt_d.st  = ST_WAIT_HI;
                        nxt_d.cnt = '0;
                    end else if (swl_s && ugl_s) begin
                        nxt_d.st = ST_LOW_ON;
                    end else if (cur_q.cnt == tmo_lim) begin
                        nxt_d.st    = ST_OFF;
                        nxt_d.fault = 1'b1;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_LOW_ON: begin
                    nxt_d.cnt = '0;
                    if (cmd == CMD_HIGH)      nxt_d.st = ST_WAIT_HI;
                    else if (cmd == CMD_SHUT) nxt_d.st = ST_INIT;
                end
                default: begin
                    nxt_d.st = ST_OFF;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st    <= ST_OFF;
            cur_q.cnt   <= '0;
            cur_q.fault <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ug_o    = (cur_q.st == ST_HIGH_ON);
    assign lg_o    = (cur_q.st == ST_LOW_ON);
    assign boot_o  = lg_o;
    assign fault_o = cur_q.fault;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ug_o && lg_o)); // R1
    AST_PG_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_s |=> (!ug_o && !lg_o)); // R2
    AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (!ug_o && !lg_o && !fault_o)); // R3
    AST_SHUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_s || (hi_s == lo_s)) |=> (!ug_o && !lg_o)); // R4
    AST_UG_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ug_o) |-> ($past(lgl_s) && $past(!lg_o))); // R5
    AST_LG_AFTER_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lg_o) |-> ($past(swl_s) && $past(ugl_s) && $past(!ug_o))); // R6
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!ug_o && !lg_o)); // R8
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && en_s) |=> fault_o); // R8
endmodule

// File: rtl/gate_seq_pair.sv
module gate_seq_pair #(
    parameter int NCH = 2,
    parameter int TW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pgood_i,
    input  logic [NCH-1:0] en_i,
    input  logic [NCH-1:0] pwm_hi_i,
    input  logic [NCH-1:0] pwm_lo_i,
    input  logic [NCH-1:0] pwm_mid_i,
    input  logic [NCH-1:0] lg_low_i,
    input  logic [NCH-1:0] sw_low_i,
    input  logic [NCH-1:0] ug_low_i,
    input  logic [TW-1:0]  tmo_lim_i,
    output logic [NCH-1:0] ug_o,
    output logic [NCH-1:0] lg_o,
    output logic [NCH-1:0] boot_o,
    output logic [NCH-1:0] fault_o
);
    localparam int NSIG = 7;

    logic pg_s;

    gate_seq_sync #(.W(1), .STAGES(2)) u_pg_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pgood_i), .q_o(pg_s)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [NSIG-1:0] raw_w, syn_w;

        assign raw_w = {en_i[c], pwm_hi_i[c], pwm_lo_i[c], pwm_mid_i[c],
                        lg_low_i[c], sw_low_i[c], ug_low_i[c]};

        gate_seq_sync #(.W(NSIG), .STAGES(2)) u_sync (
            .clk(clk), .rst_n(rst_n), .d_i(raw_w), .q_o(syn_w)
        );

        gate_seq_chan #(.TW(TW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .pg_s   (pg_s),
            .en_s   (syn_w[6]),
            .hi_s   (syn_w[5]),
            .lo_s   (syn_w[4]),
            .mid_s  (syn_w[3]),
            .lgl_s  (syn_w[2]),
            .swl_s  (syn_w[1]),
            .ugl_s  (syn_w[0]),
            .tmo_lim(tmo_lim_i),
            .ug_o   (ug_o[c]),
            .lg_o   (lg_o[c]),
            .boot_o (boot_o[c]),
            .fault_o(fault_o[c])
        );
    end
endmodule

// File: tb/gate_seq_pair_tb.sv
module gate_seq_pair_tb;
    localparam int NCH = 2;
    localparam int TW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pgood_i = 1'b0;
    logic [NCH-1:0] en_i = '0, pwm_hi_i = '0, pwm_lo_i = '0, pwm_mid_i = '0;
    logic [NCH-1:0] lg_low_i, sw_low_i, ug_low_i;
    logic [TW-1:0]  tmo_lim_i = 8'd30;
    logic [NCH-1:0] ug_o, lg_o, boot_o, fault_o;

    int errors = 0, checks = 0;
    bit done = 0;

    // bench flag model state
    logic [7:0] lg_hist [NCH];
    logic [7:0] ug_hist [NCH];
    int         dly [NCH];
    logic [NCH-1:0] ovr_lgl = '0;
    logic [2:0] lgl_h [NCH];
    logic [2:0] fl_h  [NCH];
    logic [NCH-1:0] ug_prev = '0, lg_prev = '0, ug_seen = '0;

    always #2 clk = ~clk;

    gate_seq_pair #(.NCH(NCH), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pgood_i(pgood_i), .en_i(en_i),
        .pwm_hi_i(pwm_hi_i), .pwm_lo_i(pwm_lo_i), .pwm_mid_i(pwm_mid_i),
        .lg_low_i(lg_low_i), .sw_low_i(sw_low_i), .ug_low_i(ug_low_i),
        .tmo_lim_i(tmo_lim_i), .ug_o(ug_o), .lg_o(lg_o), .boot_o(boot_o),
        .fault_o(fault_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // cmd: 0 mid, 1 high, 2 low, 3 high+low, 4 no flag (floating)
    function automatic logic [1:0] exp_gates(input int cmd, input logic en, input logic pg);
        if (!en || !pg) return 2'b00;
        if (cmd == 1) return 2'b10;
        if (cmd == 2) return 2'b01;
        return 2'b00;
    endfunction

    task automatic set_cmd(input int c, input int cmd);
        pwm_mid_i[c] = (cmd == 0);
        pwm_hi_i[c]  = (cmd == 1) || (cmd == 3);
        pwm_lo_i[c]  = (cmd == 2) || (cmd == 3);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            lg_hist[c] = '0; ug_hist[c] = '0; dly[c] = 2;
            lgl_h[c] = 3'b111; fl_h[c] = 3'b111;
        end
        lg_low_i = '1; sw_low_i = '1; ug_low_i = '1;
    end

    // monitor and feedback model, all on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                chk("R1 overlap", {7'd0, ug_o[c] & lg_o[c]}, 8'd0);
                chk("R7 boot", {7'd0, boot_o[c]}, {7'd0, lg_o[c]});
                if (ug_o[c] && !ug_prev[c]) begin
                    chk("R5 ug waits flag", {6'd0, lgl_h[c][2], lg_prev[c]}, 8'd2);
                end
                if (lg_o[c] && !lg_prev[c]) begin
                    chk("R6 lg waits flags", {7'd0, fl_h[c][2]}, 8'd1);
                end
                if (ug_o[c]) ug_seen[c] = 1'b1;
            end
        end
        for (int c = 0; c < NCH; c++) begin
            ug_prev[c] = ug_o[c];
            lg_prev[c] = lg_o[c];
            lg_hist[c] = {lg_hist[c][6:0], lg_o[c]};
            ug_hist[c] = {ug_hist[c][6:0], ug_o[c]};
            lg_low_i[c] = !ovr_lgl[c] && ((lg_hist[c] & ((8'd1 << dly[c]) - 8'd1)) == 8'd0);
            sw_low_i[c] = ((ug_hist[c] & ((8'd1 << dly[c]) - 8'd1)) == 8'd0);
            ug_low_i[c] = ((ug_hist[c] & ((8'd1 << (dly[c] > 1 ? dly[c] - 1 : 1)) - 8'd1)) == 8'd0);
            lgl_h[c] = {lgl_h[c][1:0], lg_low_i[c]};
            fl_h[c]  = {fl_h[c][1:0], sw_low_i[c] & ug_low_i[c]};
        end
    end

    initial begin
        int cmd [NCH];
        logic [1:0] e;
        void'($urandom(32'd1234));
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        chk("R3 reset gates", {6'd0, ug_o}, 8'd0);
        chk("R3 reset lg", {6'd0, lg_o}, 8'd0);
        chk("R8 reset fault", {6'd0, fault_o}, 8'd0);

        // directed: enable rise passes through init with gates low
        pgood_i = 1'b1;
        set_cmd(0, 1); set_cmd(1, 2);
        en_i = 2'b11;
        wait_n(3);
        chk("R3 init gates low", {6'd0, ug_o | lg_o}, 8'd0);
        wait_n(20);
        chk("R5 high steady", {6'd0, ug_o[0], lg_o[0]}, 8'd2);
        chk("R6 low steady", {6'd0, ug_o[1], lg_o[1]}, 8'd1);

        // directed: power-good drop
        pgood_i = 1'b0;
        wait_n(3);
        chk("R2 pg off", {6'd0, ug_o | lg_o}, 8'd0);
        pgood_i = 1'b1;
        wait_n(20);
        chk("R2 pg resume", {6'd0, ug_o[0], lg_o[1]}, 8'd3);

        // directed: decode of shutdown cases
        set_cmd(0, 0); set_cmd(1, 3);
        wait_n(4);
        chk("R4 mid off", {6'd0, ug_o[0], lg_o[0]}, 8'd0);
        chk("R4 both flags off", {6'd0, ug_o[1], lg_o[1]}, 8'd0);
        set_cmd(0, 4);
        wait_n(4);
        chk("R4 floating off", {6'd0, ug_o[0], lg_o[0]}, 8'd0);

        // directed: timeout on channel 0, channel 1 keeps running
        set_cmd(0, 2); set_cmd(1, 2);
        wait_n(20);
        ovr_lgl[0] = 1'b1;
        set_cmd(0, 1);
        wait_n(60);
        chk("R8 fault set", {7'd0, fault_o[0]}, 8'd1);
        chk("R8 gates off", {6'd0, ug_o[0], lg_o[0]}, 8'd0);
        chk("R3 other channel", {6'd0, fault_o[1], lg_o[1]}, 8'd1);
        ovr_lgl[0] = 1'b0;
        wait_n(15);
        chk("R8 fault held", {6'd0, fault_o[0], ug_o[0]}, 8'd2);
        en_i[0] = 1'b0;
        wait_n(5);
        chk("R3 fault cleared", {7'd0, fault_o[0]}, 8'd0);
        en_i[0] = 1'b1;
        wait_n(25);
        chk("R3 resume high", {6'd0, ug_o[0], lg_o[0]}, 8'd2);

        // directed: reversal during a wait on channel 1
        ovr_lgl[1] = 1'b1;
        ug_seen[1] = 1'b0;
        set_cmd(1, 1);
        wait_n(10);
        chk("R9 both off in wait", {6'd0, ug_o[1], lg_o[1]}, 8'd0);
        set_cmd(1, 2);
        wait_n(3);
        ovr_lgl[1] = 1'b0;
        wait_n(20);
        chk("R9 never rose", {7'd0, ug_seen[1]}, 8'd0);
        chk("R9 back to low", {6'd0, fault_o[1], lg_o[1]}, 8'd1);

        // random phase
        for (int it = 0; it < 300; it++) begin
            int hold;
            hold = 20 + int'($urandom_range(0, 20));
            for (int c = 0; c < NCH; c++) begin
                cmd[c] = int'($urandom_range(0, 4));
                if ($urandom_range(0, 2) != 0) cmd[c] = 1 + int'($urandom_range(0, 1));
                dly[c] = 1 + int'($urandom_range(0, 3));
                set_cmd(c, cmd[c]);
                if ($urandom_range(0, 9) == 0) en_i[c] = ~en_i[c];
            end
            if ($urandom_range(0, 14) == 0) pgood_i = ~pgood_i;
            wait_n(hold);
            for (int c = 0; c < NCH; c++) begin
                e = exp_gates(cmd[c], en_i[c], pgood_i);
                chk((cmd[c] == 1) ? "R5 random" : (cmd[c] == 2) ? "R6 random" : "R4 random",
                    {6'd0, ug_o[c], lg_o[c]}, {6'd0, e});
                chk("R8 no spurious fault", {7'd0, fault_o[c]}, 8'd0);
            end
            // quick reversal inside the wait, judged by the overlap and ordering monitors
            if ((it % 7) == 3) begin
                for (int c = 0; c < NCH; c++) begin
                    cmd[c] = (cmd[c] == 1) ? 2 : 1;
                    set_cmd(c, cmd[c]);
                end
                wait_n(3 + int'($urandom_range(0, 4)));
                for (int c = 0; c < NCH; c++) begin
                    cmd[c] = (cmd[c] == 1) ? 2 : 1;
                    set_cmd(c, cmd[c]);
                end
                wait_n(25);
                for (int c = 0; c < NCH; c++) begin
                    e = exp_gates(cmd[c], en_i[c], pgood_i);
                    chk("R9 random reversal", {6'd0, ug_o[c], lg_o[c]}, {6'd0, e});
                end
            end
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule